// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Cycle Controller

This block is a bus master that runs single memory or I/O transfers on a bus where the low address bits and the data share one set of lines. A client places a request: an address, a byte-high enable, a memory-or-I/O flag, a direction flag and write data. The controller then steps through an address phase (T1), two strobe phases (T2, T3), any number of wait phases (Tw) and a closing phase (T4). While it does so it drives the address-latch pulse, the active-low read, write and data-buffer enables, the buffer direction and the memory/IO indication.

During T1 the shared lines carry the low address. The upper address lines carry the rest of the address, and the latch pulse lets external logic hold it. After T1 the upper lines switch to a status code and the shared lines either turn around for incoming read data or carry outgoing write data. At the end of T3, and again at the end of every wait phase, the controller samples `ready`. It adds wait phases until `ready` is seen high. Read data is captured on entry to T4 and steered according to the byte lanes selected. A one-clock completion pulse follows T4.

Byte lanes are chosen by address bit 0 (low, even bank) and the byte-high enable (high, odd bank). The controller steers write bytes onto the proper lane and extracts read bytes from it, so the client always sees byte data in the low bits.

Top module: `mbus_cycle_ctrl`

## Requirements
- R1: After synchronous reset `ale` is 0, `rd_n`, `wr_n`, `den_n` and `bhe_n` are 1, `ad_oe` and `rsp_done` are 0, and `req_ready` is 1.
- R2: In the clock after a request is accepted (T1), `ale` is 1 for exactly that one clock. In that clock `ad_out` equals `req_addr[DW-1:0]` with `ad_oe` high, and `a_hi` equals `req_addr[AW-1:DW]`.
- R3: From T2 to T4, `a_hi` carries status: bit 1 is the write flag, bit 0 is the I/O flag, and all other bits are 0. From T1 to T4, `bhe_n` equals the inverted byte-high enable and `m_io` is 1 for memory and 0 for I/O. Both stay constant.
- R4: In a read, `rd_n` is 0 in T2, T3 and every Tw and 1 otherwise. `dt_r` is 0 from T1 to T4, `ad_oe` is 0 from T2 to T4, and `wr_n` stays 1.
- R5: In a write, `wr_n` is 0 in T2, T3 and every Tw. `dt_r` is 1 from T1 to T4, `ad_oe` is 1 from T2 to T4 with the steered write data on `ad_out`, and `rd_n` stays 1.
- R6: `den_n` is 1 in T1 and T4 and 0 in T2, T3 and every Tw.
- R7: `ready` is sampled only at the clock edge that ends T3 or a Tw. Each low sample adds one Tw. The value of `ready` during T1 and T2 has no effect.
- R8: Read data is captured from `ad_in` at the edge that enters T4 and is visible on `rsp_rdata` in T4. `rsp_done` is 1 for exactly the one clock after T4. `rsp_rdata` keeps its value through write cycles.
- R9: Read steering by {byte-high enable, address bit 0}: 10 returns the whole word; 11 returns the upper lane zero-extended; 00 returns the lower lane zero-extended; 01 returns 0.
- R10: Write steering: with {byte-high enable, address bit 0} = 10 the whole word is driven. In every other case the low byte of `req_wdata` is driven on both lanes.
- R11: `req_ready` is 0 from T1 to T4. A `req_valid` raised in that time is ignored: it does not change the cycle in progress and starts no cycle afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present; taken when `req_ready` is high |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_addr | input | AW | Transfer address |
| req_bhe | input | 1 | Byte-high enable (odd bank wanted), active high |
| req_io | input | 1 | 1 = I/O cycle, 0 = memory cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | DW | Write data |
| rsp_rdata | output | DW | Steered read data |
| rsp_done | output | 1 | One-clock completion pulse |
| ad_out | output | DW | Shared lines, driven value |
| ad_oe | output | 1 | Shared lines output enable |
| ad_in | input | DW | Shared lines, received value |
| a_hi | output | AW-DW | Upper address in T1, status afterwards |
| bhe_n | output | 1 | Byte-high enable, active low |
| ale | output | 1 | Address latch pulse |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| den_n | output | 1 | Data buffer enable, active low |
| dt_r | output | 1 | Buffer direction: 1 transmit, 0 receive |
| m_io | output | 1 | 1 = memory, 0 = I/O |
| ready | input | 1 | Slave ready, sampled at the end of T3 and Tw |

## Verification
The bench holds `ready` low through T1 and T2 of every cycle. A controller that sampled it too early would insert waits where none were asked for, and the strobe-length count would catch it. It runs cycles with zero to three waits and checks every phase. An off-by-one in the wait logic shows up as a strobe one clock too long or too short, or as the wrong data captured at T4. All four lane codes are exercised for reads and writes, so a swapped lane or a missing zero-extension gives a mismatch in the scoreboard. A stray request raised mid-cycle must leave the status lines and the following idle clock untouched, and a read value must survive a later write.

// File: rtl/mbc_pkg.sv
package mbc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_T1   = 3'd1,
    ST_T2   = 3'd2,
    ST_T3   = 3'd3,
    ST_TW   = 3'd4,
    ST_T4   = 3'd5
  } bus_st_e;

  typedef enum logic [1:0] {
    LN_WORD = 2'd0,
    LN_EVEN = 2'd1,
    LN_ODD  = 2'd2,
    LN_NONE = 2'd3
  } lane_e;

  // byte-lane choice from the high-bank enable and address bit 0
  function automatic lane_e lane_of(input logic bhe, input logic a0);
    case ({bhe, a0})
      2'b10:   return LN_WORD;
      2'b11:   return LN_ODD;
      2'b00:   return LN_EVEN;
      default: return LN_NONE;
    endcase
  endfunction

endpackage

// File: rtl/mbc_seq.sv
module mbc_seq
  import mbc_pkg::*;
#(
  parameter int AW = 20,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  input  logic          req_bhe,
  input  logic          req_io,
  input  logic          req_write,
  input  logic [DW-1:0] req_wdata,
  input  logic          ready,
  output bus_st_e       st,
  output bus_st_e       st_nxt,
  output logic [AW-1:0] cur_addr,
  output logic          cur_bhe,
  output logic          cur_io,
  output logic          cur_write,
  output logic [DW-1:0] cur_wdata
);

  logic [AW-1:0] lat_addr;
  logic          lat_bhe;
  logic          lat_io;
  logic          lat_write;
  logic [DW-1:0] lat_wdata;
  logic          idle;

  assign idle = (st == ST_IDLE);

  always_comb begin
    st_nxt = st;
    case (st)
      ST_IDLE: if (req_valid) st_nxt = ST_T1;
      ST_T1:   st_nxt = ST_T2;
      ST_T2:   st_nxt = ST_T3;
      ST_T3:   st_nxt = ready ? ST_T4 : ST_TW;
      ST_TW:   st_nxt = ready ? ST_T4 : ST_TW;
      ST_T4:   st_nxt = ST_IDLE;
      default: st_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      lat_addr  <= '0;
      lat_bhe   <= 1'b0;
      lat_io    <= 1'b0;
      lat_write <= 1'b0;
      lat_wdata <= '0;
    end else begin
      st <= st_nxt;
      if (idle && req_valid) begin
        lat_addr  <= req_addr;
        lat_bhe   <= req_bhe;
        lat_io    <= req_io;
        lat_write <= req_write;
        lat_wdata <= req_wdata;
      end
    end
  end

  // in idle the fields come straight from the request so T1 outputs can be registered
  assign cur_addr  = idle ? req_addr  : lat_addr;
  assign cur_bhe   = idle ? req_bhe   : lat_bhe;
  assign cur_io    = idle ? req_io    : lat_io;
  assign cur_write = idle ? req_write : lat_write;
  assign cur_wdata = idle ? req_wdata : lat_wdata;

  // R7
  wait_ins_chk: assert property (@(posedge clk) disable iff (rst)
    ((st == ST_T3 || st == ST_TW) && !ready) |=> (st == ST_TW));

  // R7
  wait_end_chk: assert property (@(posedge clk) disable iff (rst)
    ((st == ST_T3 || st == ST_TW) && ready) |=> (st == ST_T4));

  // R11
  no_restart_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_T1) |=> (st == ST_T2));

  // R11
  hold_req_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_T2) |=> $stable(lat_addr) && $stable(lat_write));

endmodule

// File: rtl/mbc_lane.sv
module mbc_lane
  import mbc_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          bhe,
  input  logic          a0,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] bus_in,
  output logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] rd_word
);

  localparam int HB = DW / 2;

  lane_e lane;
  logic [DW-1:0] dup_low;

  assign lane = lane_of(bhe, a0);

  // low byte replicated onto every lane
  genvar g;
  generate
    for (g = 0; g < 2; g++) begin : g_dup
      assign dup_low[g*HB +: HB] = wdata[HB-1:0];
    end
  endgenerate

  always_comb begin
    bus_wdata = (lane == LN_WORD) ? wdata : dup_low;
    case (lane)
      LN_WORD: rd_word = bus_in;
      LN_ODD:  rd_word = {{(DW-HB){1'b0}}, bus_in[DW-1:HB]};
      LN_EVEN: rd_word = {{(DW-HB){1'b0}}, bus_in[HB-1:0]};
      default: rd_word = '0;
    endcase
  end

endmodule

// File: rtl/mbc_drive.sv
module mbc_drive
  import mbc_pkg::*;
#(
  parameter int AW = 20,
  parameter int DW = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  bus_st_e          st,
  input  bus_st_e          st_nxt,
  input  logic [AW-1:0]    cur_addr,
  input  logic             cur_bhe,
  input  logic             cur_io,
  input  logic             cur_write,
  input  logic [DW-1:0]    bus_wdata,
  input  logic [DW-1:0]    rd_word,
  output logic [DW-1:0]    rsp_rdata,
  output logic             rsp_done,
  output logic [DW-1:0]    ad_out,
  output logic             ad_oe,
  output logic [AW-DW-1:0] a_hi,
  output logic             bhe_n,
  output logic             ale,
  output logic             rd_n,
  output logic             wr_n,
  output logic             den_n,
  output logic             dt_r,
  output logic             m_io
);

  localparam int HW = AW - DW;

  logic [HW-1:0] status;
  logic          strobe_ph;

  assign status    = {{(HW-2){1'b0}}, cur_write, cur_io};
  assign strobe_ph = (st_nxt == ST_T2) || (st_nxt == ST_T3) || (st_nxt == ST_TW);

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_rdata <= '0;
      rsp_done  <= 1'b0;
      ad_out    <= '0;
      ad_oe     <= 1'b0;
      a_hi      <= '0;
      bhe_n     <= 1'b1;
      ale       <= 1'b0;
      rd_n      <= 1'b1;
      wr_n      <= 1'b1;
      den_n     <= 1'b1;
      dt_r      <= 1'b0;
      m_io      <= 1'b0;
    end else begin
      rsp_done <= (st == ST_T4);
      if (st_nxt == ST_T4 && st != ST_T4 && !cur_write)
        rsp_rdata <= rd_word;
      ale   <= (st_nxt == ST_T1);
      rd_n  <= !(strobe_ph && !cur_write);
      wr_n  <= !(strobe_ph && cur_write);
      den_n <= !strobe_ph;
      case (st_nxt)
        ST_T1: begin
          ad_out <= cur_addr[DW-1:0];
          ad_oe  <= 1'b1;
          a_hi   <= cur_addr[AW-1:DW];
          bhe_n  <= !cur_bhe;
          dt_r   <= cur_write;
          m_io   <= !cur_io;
        end
        ST_T2, ST_T3, ST_TW, ST_T4: begin
          ad_out <= cur_write ? bus_wdata : '0;
          ad_oe  <= cur_write;
          a_hi   <= status;
          bhe_n  <= !cur_bhe;
          dt_r   <= cur_write;
          m_io   <= !cur_io;
        end
        default: begin
          ad_out <= '0;
          ad_oe  <= 1'b0;
          a_hi   <= '0;
          bhe_n  <= 1'b1;
        end
      endcase
    end
  end

  // R2
  ale_once_chk: assert property (@(posedge clk) disable iff (rst)
    ale |=> !ale);

  // R4
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(!rd_n && !wr_n));

  // R6
  den_addr_chk: assert property (@(posedge clk) disable iff (rst)
    ale |-> den_n);

  // R8
  done_once_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_done |=> !rsp_done);

  // R3
  attr_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (!rd_n || !wr_n) |-> $stable(bhe_n) && $stable(m_io) && $stable(dt_r));

endmodule

// File: rtl/mbus_cycle_ctrl.sv
module mbus_cycle_ctrl
  import mbc_pkg::*;
#(
  parameter int AW = 20,
  parameter int DW = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [AW-1:0]    req_addr,
  input  logic             req_bhe,
  input  logic             req_io,
  input  logic             req_write,
  input  logic [DW-1:0]    req_wdata,
  output logic [DW-1:0]    rsp_rdata,
  output logic             rsp_done,
  output logic [DW-1:0]    ad_out,
  output logic             ad_oe,
  input  logic [DW-1:0]    ad_in,
  output logic [AW-DW-1:0] a_hi,
  output logic             bhe_n,
  output logic             ale,
  output logic             rd_n,
  output logic             wr_n,
  output logic             den_n,
  output logic             dt_r,
  output logic             m_io,
  input  logic             ready
);

  bus_st_e       st;
  bus_st_e       st_nxt;
  logic [AW-1:0] cur_addr;
  logic          cur_bhe;
  logic          cur_io;
  logic          cur_write;
  logic [DW-1:0] cur_wdata;
  logic [DW-1:0] bus_wdata;
  logic [DW-1:0] rd_word;

  assign req_ready = (st == ST_IDLE);

  mbc_seq #(.AW(AW), .DW(DW)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_addr  (req_addr),
    .req_bhe   (req_bhe),
    .req_io    (req_io),
    .req_write (req_write),
    .req_wdata (req_wdata),
    .ready     (ready),
    .st        (st),
    .st_nxt    (st_nxt),
    .cur_addr  (cur_addr),
    .cur_bhe   (cur_bhe),
    .cur_io    (cur_io),
    .cur_write (cur_write),
    .cur_wdata (cur_wdata)
  );

  mbc_lane #(.DW(DW)) u_lane (
    .bhe       (cur_bhe),
    .a0        (cur_addr[0]),
    .wdata     (cur_wdata),
    .bus_in    (ad_in),
    .bus_wdata (bus_wdata),
    .rd_word   (rd_word)
  );

  mbc_drive #(.AW(AW), .DW(DW)) u_drive (
    .clk       (clk),
    .rst       (rst),
    .st        (st),
    .st_nxt    (st_nxt),
    .cur_addr  (cur_addr),
    .cur_bhe   (cur_bhe),
    .cur_io    (cur_io),
    .cur_write (cur_write),
    .bus_wdata (bus_wdata),
    .rd_word   (rd_word),
    .rsp_rdata (rsp_rdata),
    .rsp_done  (rsp_done),
    .ad_out    (ad_out),
    .ad_oe     (ad_oe),
    .a_hi      (a_hi),
    .bhe_n     (bhe_n),
    .ale       (ale),
    .rd_n      (rd_n),
    .wr_n      (wr_n),
    .den_n     (den_n),
    .dt_r      (dt_r),
    .m_io      (m_io)
  );

  // R11
  busy_ready_chk: assert property (@(posedge clk) disable iff (rst)
    ale |-> !req_ready);

endmodule

// File: tb/tb_mbus_cycle_ctrl.sv
module tb_mbus_cycle_ctrl;

  localparam int AW = 20;
  localparam int DW = 16;
  localparam int HW = AW - DW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [AW-1:0] req_addr = '0;
  logic          req_bhe = 1'b0;
  logic          req_io = 1'b0;
  logic          req_write = 1'b0;
  logic [DW-1:0] req_wdata = '0;
  logic [DW-1:0] rsp_rdata;
  logic          rsp_done;
  logic [DW-1:0] ad_out;
  logic          ad_oe;
  logic [DW-1:0] ad_in = '0;
  logic [HW-1:0] a_hi;
  logic          bhe_n, ale, rd_n, wr_n, den_n, dt_r, m_io;
  logic          ready = 1'b0;

  int n_chk = 0;
  int n_err = 0;
  int n_done = 0;
  int n_sent = 0;
  bit finished = 1'b0;
  logic [DW-1:0] last_rd = '0;

  typedef struct packed {
    logic          is_read;
    logic [DW-1:0] data;
  } exp_t;
  exp_t exp_q[$];

  always #4 clk = ~clk;

  mbus_cycle_ctrl #(.AW(AW), .DW(DW)) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_bhe(req_bhe), .req_io(req_io),
    .req_write(req_write), .req_wdata(req_wdata), .rsp_rdata(rsp_rdata),
    .rsp_done(rsp_done), .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in),
    .a_hi(a_hi), .bhe_n(bhe_n), .ale(ale), .rd_n(rd_n), .wr_n(wr_n),
    .den_n(den_n), .dt_r(dt_r), .m_io(m_io), .ready(ready)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [DW-1:0] exp_read(input logic bhe, input logic a0, input logic [DW-1:0] bus);
    case ({bhe, a0})
      2'b10:   return bus;
      2'b11:   return {8'h00, bus[15:8]};
      2'b00:   return {8'h00, bus[7:0]};
      default: return '0;
    endcase
  endfunction

  function automatic logic [DW-1:0] exp_wbus(input logic bhe, input logic a0, input logic [DW-1:0] w);
    if ({bhe, a0} == 2'b10) return w;
    return {w[7:0], w[7:0]};
  endfunction

  // checks shared by T2, T3 and Tw
  task automatic chk_mid(input logic wr, input logic io, input logic bhe, input logic [DW-1:0] wb, input string ph);
    chk(ale == 1'b0, {"R2 ale low in ", ph}, ale, 0);
    chk(a_hi == {{(HW-2){1'b0}}, wr, io}, {"R3 status in ", ph}, a_hi, {wr, io});
    chk(bhe_n == !bhe && m_io == !io, {"R3 attrs in ", ph}, {bhe_n, m_io}, {!bhe, !io});
    chk(den_n == 1'b0, {"R6 den in ", ph}, den_n, 0);
    if (wr) begin
      chk(wr_n == 1'b0 && rd_n == 1'b1, {"R5 strobes in ", ph}, {rd_n, wr_n}, 2'b10);
      chk(dt_r == 1'b1 && ad_oe == 1'b1, {"R5 dir/oe in ", ph}, {dt_r, ad_oe}, 2'b11);
      chk(ad_out == wb, {"R10 write lanes in ", ph}, ad_out, wb);
    end else begin
      chk(rd_n == 1'b0 && wr_n == 1'b1, {"R4 strobes in ", ph}, {rd_n, wr_n}, 2'b01);
      chk(dt_r == 1'b0 && ad_oe == 1'b0, {"R4 dir/oe in ", ph}, {dt_r, ad_oe}, 2'b00);
    end
  endtask

  task automatic run_cyc(input logic [AW-1:0] addr, input logic bhe, input logic io,
                         input logic wr, input logic [DW-1:0] wdata,
                         input logic [DW-1:0] rdbus, input int nwait);
    logic [DW-1:0] wb;
    logic [DW-1:0] er;
    int strobes;
    wb = exp_wbus(bhe, addr[0], wdata);
    er = exp_read(bhe, addr[0], rdbus);
    strobes = 0;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_addr = addr; req_bhe = bhe; req_io = io; req_write = wr; req_wdata = wdata;
    req_valid = 1'b1; ready = 1'b0; ad_in = rdbus;
    @(negedge clk); // T1
    chk(ale == 1'b1, "R2 ale in T1", ale, 1);
    chk(ad_out == addr[DW-1:0] && ad_oe == 1'b1, "R2 address on shared lines", ad_out, addr[DW-1:0]);
    chk(a_hi == addr[AW-1:DW], "R2 upper address", a_hi, addr[AW-1:DW]);
    chk(den_n == 1'b1 && rd_n == 1'b1 && wr_n == 1'b1, "R6 T1 enables off", {den_n, rd_n, wr_n}, 3'b111);
    chk(bhe_n == !bhe && m_io == !io && dt_r == wr, "R3 attrs in T1", {bhe_n, m_io, dt_r}, {!bhe, !io, wr});
    chk(req_ready == 1'b0, "R11 busy in T1", req_ready, 0);
    // stray request while busy (R11)
    req_addr = ~addr; req_write = !wr; req_io = !io;
    @(negedge clk); // T2
    chk_mid(wr, io, bhe, wb, "T2"); strobes++;
    req_valid = 1'b0;
    @(negedge clk); // T3
    chk_mid(wr, io, bhe, wb, "T3"); strobes++;
    ready = (nwait == 0);
    for (int k = 0; k < nwait; k++) begin
      @(negedge clk); // Tw
      chk_mid(wr, io, bhe, wb, "Tw R7"); strobes++;
      if (k == nwait - 1) ready = 1'b1;
    end
    @(negedge clk); // T4
    ready = 1'b0;
    chk(strobes == 2 + nwait, "R7 strobe length", strobes, 2 + nwait);
    chk(rd_n == 1'b1 && wr_n == 1'b1 && den_n == 1'b1, "R6 T4 enables off", {rd_n, wr_n, den_n}, 3'b111);
    chk(rsp_done == 1'b0, "R8 no done in T4", rsp_done, 0);
    chk(ad_oe == wr, "R4 R5 oe in T4", ad_oe, wr);
    if (wr) chk(rsp_rdata == last_rd, "R8 read data held over write", rsp_rdata, last_rd);
    else begin
      chk(rsp_rdata == er, "R8 R9 data at T4", rsp_rdata, er);
      last_rd = er;
    end
    exp_q.push_back('{is_read: !wr, data: er});
    n_sent++;
    @(negedge clk); // done clock
    @(negedge clk);
    chk(ale == 1'b0 && req_ready == 1'b1, "R11 stray request ignored", {ale, req_ready}, 2'b01);
  endtask

  // monitor: pops expected results when the design reports completion
  always @(negedge clk) begin
    if (!rst && rsp_done) begin
      n_done++;
      if (exp_q.size() == 0) chk(1'b0, "R8 unexpected done", 1, 0);
      else begin
        exp_t e;
        e = exp_q.pop_front();
        if (e.is_read) chk(rsp_rdata == e.data, "R8 R9 scoreboard read", rsp_rdata, e.data);
        else chk(1'b1, "R8 write done", 1, 1);
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(ale == 0 && rd_n && wr_n && den_n && bhe_n && !ad_oe && !rsp_done && req_ready,
        "R1 reset state", {ale, rd_n, wr_n, den_n, bhe_n, ad_oe, rsp_done, req_ready}, 8'b01111001);
    rst = 1'b0;
    run_cyc(20'hA1234, 1'b1, 1'b0, 1'b0, 16'h0, 16'hBEEF, 0); // word mem read
    run_cyc(20'h50010, 1'b1, 1'b1, 1'b1, 16'hC3A5, 16'h0, 2); // word io write, 2 waits
    run_cyc(20'h00777, 1'b1, 1'b0, 1'b0, 16'h0, 16'h5A9C, 1); // odd byte read
    run_cyc(20'h3F0F2, 1'b0, 1'b1, 1'b0, 16'h0, 16'h12F0, 0); // even byte io read
    run_cyc(20'h00003, 1'b0, 1'b0, 1'b0, 16'h0, 16'hFFFF, 0); // no lane read
    run_cyc(20'h12345, 1'b1, 1'b0, 1'b1, 16'h9E3C, 16'h0, 0); // odd byte write
    run_cyc(20'hFFFFE, 1'b0, 1'b0, 1'b1, 16'h77A1, 16'h0, 3); // even byte write, 3 waits
    run_cyc(20'h08000, 1'b1, 1'b1, 1'b0, 16'h0, 16'h0F1E, 3); // word io read, 3 waits
    repeat (3) @(negedge clk);
    chk(n_done == n_sent && exp_q.size() == 0, "R8 one done per cycle", n_done, n_sent);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog R7 actual=hung expected=complete");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

endmodule